// File: doc/BRIEF.md
# PTP System Time Counter

This block holds the precise time of day used to stamp Ethernet frames for IEEE 1588. The time is a 64-bit value made of a 32-bit seconds count and a 32-bit nanoseconds count, and the block runs entirely in the PTP reference clock domain. The rate is set by a 32-bit addend. The addend is summed into a 32-bit phase accumulator on every clock, and only a carry out of that accumulator moves the time forward by a programmable nanosecond step. Software can therefore trim the clock frequency in very small amounts and keep the time linear between synchronisation messages.

Software writes through a simple register port. It can load a new time outright, or it can add or subtract an offset in one step, with carry and borrow between the nanoseconds and seconds fields. Two capture strobes freeze the current time into capture registers: one for the start-of-frame delimiter of a transmitted frame and one for any received frame. Each capture has a valid flag that a read pulse clears. A one-cycle pulse marks every seconds rollover produced by normal counting.

Top module: `ptp_systime`

## Requirements
- R1: After reset, time seconds and nanoseconds are 0, the accumulator is 0, the addend takes its reset parameter (default 0x8000_0000), the nanosecond step is 20, and busy, pps and both capture valid flags are 0.
- R2: On each clock edge the addend is added into the 32-bit accumulator modulo 2^32. The nanoseconds advance by the step only on an edge where that sum carries out of bit 31, so an addend of 0 freezes the time.
- R3: When nanoseconds plus the step reaches 1,000,000,000 or more, the nanoseconds become that sum minus 1,000,000,000 and the seconds increase by one. pps is then high for exactly the following cycle. Nanoseconds never reach 1,000,000,000.
- R4: Writes use wrAddr 0 for the update seconds, 1 for the update nanoseconds, 2 for the addend, 3 for the step (low 8 bits of wrData), and 4 for commands. A write to address 1 of 1,000,000,000 or more is ignored. A new addend or step is used from the edge after the write.
- R5: An init command (command bit 0) loads the time with the update seconds and update nanoseconds.
- R6: An add command (command bit 1) adds the update value to the time. A nanosecond result of 1,000,000,000 or more wraps and carries one into seconds, and seconds wrap modulo 2^32.
- R7: A subtract command (command bit 2) subtracts the update value from the time. A nanosecond underflow borrows one from seconds, and seconds wrap modulo 2^32.
- R8: A command written at edge n raises busy for the one cycle after it. The time is changed at edge n+1, and busy is low again afterwards. An accumulator carry at edge n+1 adds no step, but the accumulator still advances.
- R9: When several command bits are set, init wins over add and add wins over subtract. A command write made while busy is high is ignored.
- R10: Capture index 0 (transmit delimiter) and index 1 (receive frame) each copy the time shown on the outputs in the cycle their strobe is high and set their valid flag. A read pulse clears the flag. A strobe and a read in the same cycle leave the flag set with the new time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PTP reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| capStrobe | input | NUM_CAP | Capture strobes (0 transmit delimiter, 1 receive frame) |
| capRead | input | NUM_CAP | Read pulses that clear the capture valid flags |
| timeSec | output | 32 | Current seconds |
| timeNsec | output | 32 | Current nanoseconds |
| ppsPulse | output | 1 | One-cycle pulse after each seconds rollover caused by counting |
| busy | output | 1 | A command is pending and will be applied at the next edge |
| capSec | output | NUM_CAP x 32 | Captured seconds per source |
| capNsec | output | NUM_CAP x 32 | Captured nanoseconds per source |
| capValid | output | NUM_CAP | Capture valid flags |

## Verification
The functions that can land in one cycle are an accumulator carry and a pending command being applied. Capture strobes and read pulses can also coincide with each other and with both of those. The bench sets the addend close to all ones so that nearly every edge carries. It then issues init, add and subtract commands and fires strobes and reads together, so a command edge always meets a carry. A behavioural model that knows only the requirements follows the inputs edge by edge. Every cycle it is compared with the time, pps, busy and capture outputs, which shows whether the carry was dropped and whether the capture kept the time from before the update.

// File: rtl/ptp_systime_pkg.sv
package ptp_systime_pkg;

  localparam int TIME_W = 32;
  localparam logic [TIME_W-1:0] NSEC_PER_SEC = 32'd1_000_000_000;

  localparam logic [2:0] ADDR_UPD_SEC  = 3'd0;
  localparam logic [2:0] ADDR_UPD_NSEC = 3'd1;
  localparam logic [2:0] ADDR_ADDEND   = 3'd2;
  localparam logic [2:0] ADDR_STEP     = 3'd3;
  localparam logic [2:0] ADDR_CMD      = 3'd4;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_INIT = 2'd1,
    CMD_ADD  = 2'd2,
    CMD_SUB  = 2'd3
  } tsCmd_e;

  typedef struct packed {
    logic doInit;
    logic doAdd;
    logic doSub;
    logic doInc;
  } tsStrobe_t;

endpackage

// File: rtl/ptp_systime_ctrl.sv
module ptp_systime_ctrl
  import ptp_systime_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int INC_W = 8,
  parameter logic [INC_W-1:0] INC_RST = 8'd20,
  parameter logic [ACC_W-1:0] ADDEND_RST = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [TIME_W-1:0] wrData,
  output tsStrobe_t         strobe,
  output logic [TIME_W-1:0] updSec,
  output logic [TIME_W-1:0] updNsec,
  output logic [INC_W-1:0]  incStep,
  output logic              busy
);

  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   accSum;
  logic             accCarry;
  tsCmd_e           pendCmd;
  tsCmd_e           wrCmd;
  logic             cmdWrite;

  assign accSum   = {1'b0, acc} + {1'b0, addend};
  assign accCarry = accSum[ACC_W];
  assign cmdWrite = wrEn && (wrAddr == ADDR_CMD);
  assign busy     = (pendCmd != CMD_NONE);

  // Priority: init over add over subtract
  always_comb begin
    if (wrData[0])      wrCmd = CMD_INIT;
    else if (wrData[1]) wrCmd = CMD_ADD;
    else if (wrData[2]) wrCmd = CMD_SUB;
    else                wrCmd = CMD_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else begin
      acc <= accSum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCmd <= CMD_NONE;
    end else if (pendCmd != CMD_NONE) begin
      pendCmd <= CMD_NONE;
    end else if (cmdWrite) begin
      pendCmd <= wrCmd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updSec  <= '0;
      updNsec <= '0;
      addend  <= ADDEND_RST;
      incStep <= INC_RST;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_UPD_SEC:  updSec <= wrData;
        ADDR_UPD_NSEC: if (wrData < NSEC_PER_SEC) updNsec <= wrData;
        ADDR_ADDEND:   addend <= wrData[ACC_W-1:0];
        ADDR_STEP:     incStep <= wrData[INC_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.doInit = (pendCmd == CMD_INIT);
    strobe.doAdd  = (pendCmd == CMD_ADD);
    strobe.doSub  = (pendCmd == CMD_SUB);
    strobe.doInc  = accCarry && (pendCmd == CMD_NONE);
  end

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy); // R8
  AST_UPD_NSEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    updNsec < NSEC_PER_SEC); // R4
  AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(addend)) |-> (acc == ACC_W'($past(acc) + addend))); // R2

endmodule

// File: rtl/ptp_systime_dp.sv
module ptp_systime_dp
  import ptp_systime_pkg::*;
#(
  parameter int INC_W   = 8,
  parameter int NUM_CAP = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  tsStrobe_t                       strobe,
  input  logic [TIME_W-1:0]               updSec,
  input  logic [TIME_W-1:0]               updNsec,
  input  logic [INC_W-1:0]                incStep,
  input  logic [NUM_CAP-1:0]              capStrobe,
  input  logic [NUM_CAP-1:0]              capRead,
  output logic [TIME_W-1:0]               timeSec,
  output logic [TIME_W-1:0]               timeNsec,
  output logic                            ppsPulse,
  output logic [NUM_CAP-1:0][TIME_W-1:0]  capSec,
  output logic [NUM_CAP-1:0][TIME_W-1:0]  capNsec,
  output logic [NUM_CAP-1:0]              capValid
);

  logic [TIME_W:0]   incSum;
  logic [TIME_W:0]   addSum;
  logic              incRoll;
  logic              addRoll;
  logic              subBorrow;
  logic [TIME_W-1:0] secNext;
  logic [TIME_W-1:0] nsecNext;
  logic              ppsNext;

  assign incSum    = {1'b0, timeNsec} + (TIME_W+1)'(incStep);
  assign addSum    = {1'b0, timeNsec} + {1'b0, updNsec};
  assign incRoll   = incSum >= {1'b0, NSEC_PER_SEC};
  assign addRoll   = addSum >= {1'b0, NSEC_PER_SEC};
  assign subBorrow = timeNsec < updNsec;

  always_comb begin
    secNext  = timeSec;
    nsecNext = timeNsec;
    ppsNext  = 1'b0;
    if (strobe.doInit) begin
      secNext  = updSec;
      nsecNext = updNsec;
    end else if (strobe.doAdd) begin
      secNext  = timeSec + updSec + TIME_W'(addRoll);
      nsecNext = addRoll ? TIME_W'(addSum - {1'b0, NSEC_PER_SEC}) : addSum[TIME_W-1:0];
    end else if (strobe.doSub) begin
      secNext  = timeSec - updSec - TIME_W'(subBorrow);
      nsecNext = subBorrow ? (timeNsec + NSEC_PER_SEC - updNsec) : (timeNsec - updNsec);
    end else if (strobe.doInc) begin
      if (incRoll) begin
        secNext  = timeSec + 1'b1;
        nsecNext = TIME_W'(incSum - {1'b0, NSEC_PER_SEC});
        ppsNext  = 1'b1;
      end else begin
        nsecNext = incSum[TIME_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeSec  <= '0;
      timeNsec <= '0;
      ppsPulse <= 1'b0;
    end else begin
      timeSec  <= secNext;
      timeNsec <= nsecNext;
      ppsPulse <= ppsNext;
    end
  end

  for (genvar gi = 0; gi < NUM_CAP; gi++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capSec[gi]   <= '0;
        capNsec[gi]  <= '0;
        capValid[gi] <= 1'b0;
      end else if (capStrobe[gi]) begin
        capSec[gi]   <= timeSec;
        capNsec[gi]  <= timeNsec;
        capValid[gi] <= 1'b1;
      end else if (capRead[gi]) begin
        capValid[gi] <= 1'b0;
      end
    end

    AST_CAP_SET: assert property (@(posedge clk) disable iff (!rstN)
      capStrobe[gi] |=> (capValid[gi] && capSec[gi] == $past(timeSec)
                         && capNsec[gi] == $past(timeNsec))); // R10
  end

  AST_NSEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    timeNsec < NSEC_PER_SEC); // R3
  AST_PPS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ppsPulse |=> !ppsPulse); // R3
  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doInit |=> (timeSec == $past(updSec) && timeNsec == $past(updNsec))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> ($stable(timeSec) && $stable(timeNsec))); // R2

endmodule

// File: rtl/ptp_systime.sv
module ptp_systime
  import ptp_systime_pkg::*;
#(
  parameter int NUM_CAP = 2,
  parameter int ACC_W   = 32,
  parameter int INC_W   = 8,
  parameter logic [INC_W-1:0] INC_RST = 8'd20,
  parameter logic [ACC_W-1:0] ADDEND_RST = 32'h8000_0000
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [2:0]                     wrAddr,
  input  logic [31:0]                    wrData,
  input  logic [NUM_CAP-1:0]             capStrobe,
  input  logic [NUM_CAP-1:0]             capRead,
  output logic [31:0]                    timeSec,
  output logic [31:0]                    timeNsec,
  output logic                           ppsPulse,
  output logic                           busy,
  output logic [NUM_CAP-1:0][31:0]       capSec,
  output logic [NUM_CAP-1:0][31:0]       capNsec,
  output logic [NUM_CAP-1:0]             capValid
);

  tsStrobe_t         strobe;
  logic [TIME_W-1:0] updSec;
  logic [TIME_W-1:0] updNsec;
  logic [INC_W-1:0]  incStep;

  ptp_systime_ctrl #(
    .ACC_W(ACC_W), .INC_W(INC_W), .INC_RST(INC_RST), .ADDEND_RST(ADDEND_RST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .updSec(updSec), .updNsec(updNsec), .incStep(incStep),
    .busy(busy)
  );

  ptp_systime_dp #(
    .INC_W(INC_W), .NUM_CAP(NUM_CAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .updSec(updSec), .updNsec(updNsec),
    .incStep(incStep), .capStrobe(capStrobe), .capRead(capRead),
    .timeSec(timeSec), .timeNsec(timeNsec), .ppsPulse(ppsPulse),
    .capSec(capSec), .capNsec(capNsec), .capValid(capValid)
  );

endmodule

// File: tb/ptp_systime_tb.sv
module ptp_systime_tb;

  localparam longint TWO32 = 64'h1_0000_0000;
  localparam longint BILLION = 64'd1_000_000_000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0] capStrobe = '0;
  logic [1:0] capRead = '0;
  logic [31:0] timeSec, timeNsec;
  logic ppsPulse, busy;
  logic [1:0][31:0] capSec, capNsec;
  logic [1:0] capValid;

  always #5 clk = ~clk;

  ptp_systime u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .capStrobe(capStrobe), .capRead(capRead), .timeSec(timeSec), .timeNsec(timeNsec),
    .ppsPulse(ppsPulse), .busy(busy), .capSec(capSec), .capNsec(capNsec),
    .capValid(capValid)
  );

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit done = 0;
  int ppsSeen = 0;
  int busySeen = 0;

  // Behavioural reference model
  longint mAcc, mAddend, mSec, mNsec, mStep, mUpdSec, mUpdNsec, mSum;
  int mPend;
  bit mPps, mCarry;
  longint mCapSec[2];
  longint mCapNsec[2];
  bit mCapV[2];

  always @(posedge clk) begin
    if (!rstN) begin
      mAcc = 0; mAddend = 64'h8000_0000; mSec = 0; mNsec = 0; mStep = 20;
      mUpdSec = 0; mUpdNsec = 0; mPend = 0; mPps = 0;
      for (int i = 0; i < 2; i++) begin mCapSec[i] = 0; mCapNsec[i] = 0; mCapV[i] = 0; end
    end else begin
      mSum = mAcc + mAddend;
      mCarry = (mSum >= TWO32);
      mAcc = mSum % TWO32;
      for (int i = 0; i < 2; i++) begin
        if (capStrobe[i]) begin mCapSec[i] = mSec; mCapNsec[i] = mNsec; mCapV[i] = 1; end
        else if (capRead[i]) mCapV[i] = 0;
      end
      mPps = 0;
      if (mPend == 1) begin
        mSec = mUpdSec; mNsec = mUpdNsec;
      end else if (mPend == 2) begin
        mNsec = mNsec + mUpdNsec; mSec = mSec + mUpdSec;
        if (mNsec >= BILLION) begin mNsec = mNsec - BILLION; mSec = mSec + 1; end
        mSec = mSec % TWO32;
      end else if (mPend == 3) begin
        mNsec = mNsec - mUpdNsec; mSec = mSec - mUpdSec;
        if (mNsec < 0) begin mNsec = mNsec + BILLION; mSec = mSec - 1; end
        mSec = (mSec + 2 * TWO32) % TWO32;
      end else if (mCarry) begin
        mNsec = mNsec + mStep;
        if (mNsec >= BILLION) begin
          mNsec = mNsec - BILLION; mSec = (mSec + 1) % TWO32; mPps = 1;
        end
      end
      if (mPend != 0) mPend = 0;
      else if (wrEn && wrAddr == 3'd4) begin
        if (wrData[0]) mPend = 1;
        else if (wrData[1]) mPend = 2;
        else if (wrData[2]) mPend = 3;
      end
      if (wrEn) begin
        case (wrAddr)
          3'd0: mUpdSec = longint'(wrData);
          3'd1: if (longint'(wrData) < BILLION) mUpdNsec = longint'(wrData);
          3'd2: mAddend = longint'(wrData);
          3'd3: mStep = longint'(wrData[7:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(timeSec == mSec[31:0], "seconds", timeSec, mSec);
      check(timeNsec == mNsec[31:0], "nanoseconds", timeNsec, mNsec);
      check(ppsPulse == mPps, "pps", ppsPulse, mPps);
      check(busy == (mPend != 0), "busy", busy, mPend != 0);
      for (int i = 0; i < 2; i++) begin
        check(capValid[i] == mCapV[i], $sformatf("capValid[%0d]", i), capValid[i], mCapV[i]);
        if (mCapV[i]) begin
          check(capSec[i] == mCapSec[i][31:0], $sformatf("capSec[%0d]", i), capSec[i], mCapSec[i]);
          check(capNsec[i] == mCapNsec[i][31:0], $sformatf("capNsec[%0d]", i), capNsec[i], mCapNsec[i]);
        end
      end
      if (ppsPulse) ppsSeen++;
      if (busy) busySeen++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cap(input logic [1:0] s, input logic [1:0] r);
    capStrobe = s; capRead = r;
    @(negedge clk);
    capStrobe = '0; capRead = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held
    check(timeSec == 0 && timeNsec == 0, "reset time", timeNsec, 0);
    check(!busy && !ppsPulse && capValid == 2'b00, "reset flags", {busy, ppsPulse, capValid}, 0);
    rstN = 1'b1;
    idle(1);
    curReq = "R1"; idle(2);
    curReq = "R2"; idle(20);
    curReq = "R4"; wr(3'd2, 32'h4000_0000); idle(12);
    wr(3'd3, 32'h0000_0107); idle(10);
    curReq = "R2"; wr(3'd2, 32'h0); idle(10);
    check(busySeen == 0, "no busy without command", busySeen, 0);
    wr(3'd2, 32'hFFFF_FFFF);
    curReq = "R4"; wr(3'd1, 32'd1_500_000_000); idle(2);
    wr(3'd3, 32'd50);
    curReq = "R5"; wr(3'd0, 32'd7); wr(3'd1, 32'd999_999_800); wr(3'd4, 32'h1); idle(3);
    curReq = "R3"; idle(10);
    check(ppsSeen > 0, "pps observed", ppsSeen, 1);
    curReq = "R6"; wr(3'd0, 32'd3); wr(3'd1, 32'd600_000_000); wr(3'd4, 32'h2); idle(3);
    wr(3'd0, 32'hFFFF_FFFE); wr(3'd4, 32'h2); idle(3);
    curReq = "R7"; wr(3'd0, 32'd100); wr(3'd1, 32'd900_000_000); wr(3'd4, 32'h4); idle(3);
    wr(3'd0, 32'd0); wr(3'd1, 32'd999_999_999); wr(3'd4, 32'h4); idle(3);
    curReq = "R9"; wr(3'd0, 32'd42); wr(3'd1, 32'd5); wr(3'd4, 32'h7); idle(3);
    wr(3'd4, 32'h6); idle(3);
    wr(3'd4, 32'h2); wr(3'd4, 32'h1); idle(3);
    curReq = "R8"; wr(3'd2, 32'hFFFF_FFF0);
    for (int k = 0; k < 6; k++) begin wr(3'd4, 32'h2); idle(k % 3); end
    check(busySeen > 0, "busy observed", busySeen, 1);
    curReq = "R10"; cap(2'b01, 2'b00); idle(3);
    cap(2'b00, 2'b01); idle(2);
    cap(2'b10, 2'b00); idle(1);
    cap(2'b10, 2'b10); idle(1);
    cap(2'b11, 2'b00); cap(2'b00, 2'b11); idle(2);
    wr(3'd4, 32'h1); cap(2'b01, 2'b10); idle(2);
    wr(3'd4, 32'h2); capStrobe = 2'b11; @(negedge clk); capStrobe = '0; idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule